// File: doc/BRIEF.md
# SD host command issue engine

This block is the command path of an SD/MMC host controller. Software first loads a 32-bit argument and then writes a 16-bit command word. Writing the command word launches the command. The engine serialises a 48-bit frame onto the CMD line, one bit per SD clock. It then waits for a response of the length the command word selects and captures that response into four 32-bit response words. For a busy-type response it also holds the command open until the card releases DAT0.

Two inhibit flags tell software when a new command, or a command that uses the data lines, may be issued. Completion, response timeout, CRC mismatch and index mismatch are reported as single-cycle pulses to a separate interrupt status block. Any of the three errors also raises an error summary pulse. All logic runs on the SD clock.

Command word layout:
- Bits [13:8]: command index.
- Bit 5: data present.
- Bit 4: index check enable.
- Bit 3: CRC check enable.
- Bits [1:0]: response type.

All other bits are ignored.

Top module: `sd_cmd_engine`

## Requirements
- R1: The cycle after an accepted command write, `cmdOe` goes high for exactly 48 cycles. During those cycles `cmdOut` carries, MSB first: a 0 start bit, a 1 transmission bit, the 6-bit index, the 32-bit argument, a 7-bit CRC and a 1 end bit. When not transmitting, `cmdOut` idles at 1.
- R2: The frame CRC uses the generator x^7 + x^3 + 1 with zero initial value over the first 40 frame bits. For index 0 with argument 0 the final frame byte is 0x95. For index 8 with argument 0x1AA it is 0x87.
- R3: `cmdInhibit` is high from the cycle after an accepted command write until the completion or timeout pulse. A command write while `cmdInhibit` is high is ignored.
- R4: `datInhibit` rises with the launch when the data-present bit is set or the response type is 11. It clears when a busy phase ends, on a timeout of a busy-type command, or one cycle after an `xferDone` pulse. It resets low.
- R5: With response type 00, `cmdComplete` pulses in the first cycle after the end bit, without waiting for a response.
- R6: With response type 10, the engine waits for a 0 start bit on `cmdIn` and then takes 48 bits in total. `rsp0` then holds response bits [39:8], and `cmdComplete` pulses in the cycle after the final bit.
- R7: With response type 01, the engine takes 136 bits. The 8 header bits and the final CRC/end byte are dropped, and the 120 bits in between are stored right-aligned: {rsp3,rsp2,rsp1,rsp0} = {8'h00, bits[127:8]}.
- R8: When CRC check (bit 3) is set, a 48-bit response whose bits [7:1] differ from the CRC7 of its bits [47:8] pulses `crcErr` and `errSummary` with the end of reception. With the check clear, no error is raised.
- R9: When index check (bit 4) is set, a 48-bit response whose bits [45:40] differ from the issued index pulses `indexErr` and `errSummary`.
- R10: If `cmdIn` stays high for TMO_CYCLES (64) cycles after the end bit, `timeoutErr` and `errSummary` pulse in the 65th cycle after the last transmitted bit. `cmdComplete` does not pulse, and `cmdInhibit` drops in that cycle.
- R11: With response type 11, after reception the engine waits while `dat0In` is low. `cmdComplete` pulses in the cycle after `dat0In` is sampled high. `dat0Level` always shows the live DAT0 level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | SD clock |
| rstN | input | 1 | Active-low synchronous reset |
| argWrEn | input | 1 | Argument register write strobe |
| argWrData | input | 32 | Argument write value |
| cmdWrEn | input | 1 | Command word write strobe (launches) |
| cmdWrData | input | 16 | Command word value |
| xferDone | input | 1 | Data transfer finished pulse from data path |
| cmdIn | input | 1 | CMD line level from card |
| dat0In | input | 1 | DAT0 line level from card |
| cmdOut | output | 1 | CMD line drive value |
| cmdOe | output | 1 | CMD line output enable |
| cmdInhibit | output | 1 | Command path busy |
| datInhibit | output | 1 | Data lines reserved |
| dat0Level | output | 1 | Live DAT0 level |
| rsp0 | output | 32 | Response word 0 |
| rsp1 | output | 32 | Response word 1 |
| rsp2 | output | 32 | Response word 2 |
| rsp3 | output | 32 | Response word 3 |
| cmdComplete | output | 1 | Command complete pulse |
| timeoutErr | output | 1 | Response timeout pulse |
| crcErr | output | 1 | Response CRC error pulse |
| indexErr | output | 1 | Response index error pulse |
| errSummary | output | 1 | Any-error pulse |

## Verification
The bench builds the engine with the default 64-cycle response window. That keeps an exact count of the timeout cycle affordable: it sweeps every cycle of the window and checks the pulse in the 65th. A behavioural card model in the bench answers each frame with a CRC it computes itself, corrupting the CRC or index on demand. The bench captures every transmitted bit and compares it against the frame it expects. This reaches all four response types, both check enables, the busy hold on DAT0, and a write attempted while a command is in flight.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;
  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int IDX_W      = 6;
  localparam int ARG_W      = 32;
  localparam int CRC_W      = 7;
  localparam int HEAD_BITS  = FRAME_BITS - CRC_W - 1;
  localparam int RX_KEEP    = LONG_BITS - 9;

  typedef enum logic [1:0] {
    RSP_NONE  = 2'b00,
    RSP_LONG  = 2'b01,
    RSP_SHORT = 2'b10,
    RSP_BUSY  = 2'b11
  } rspType_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_WAIT, ST_RECV, ST_BUSY
  } state_e;

  typedef struct packed {
    logic launch;
    logic txShift;
    logic rxShift;
    logic store;
  } strobe_t;

  function automatic logic [CRC_W-1:0] crc7(input logic [HEAD_BITS-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = HEAD_BITS - 1; i >= 0; i--) begin
      fb = d[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return c;
  endfunction
endpackage

// File: rtl/sd_cmd_ctrl.sv
module sd_cmd_ctrl
  import sd_cmd_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdWrEn,
  input  rspType_e wrRspType,
  input  logic     wrDataPres,
  input  rspType_e rspType,
  input  logic     cmdIn,
  input  logic     dat0In,
  input  logic     xferDone,
  output strobe_t  strb,
  output logic     cmdInhibit,
  output logic     datInhibit,
  output logic     cmdComplete,
  output logic     timeoutErr
);
  localparam int CNT_MAX = (LONG_BITS > TMO_CYCLES) ? LONG_BITS : TMO_CYCLES;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  state_e state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] rxLast;

  assign rxLast = (rspType == RSP_LONG) ? CNT_W'(LONG_BITS - 2) : CNT_W'(FRAME_BITS - 2);
  assign cmdInhibit = (state != ST_IDLE);

  always_comb begin
    strb.launch  = (state == ST_IDLE) && cmdWrEn;
    strb.txShift = (state == ST_SEND);
    strb.rxShift = (state == ST_RECV);
    strb.store   = (state == ST_RECV) && (cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      cnt         <= '0;
      datInhibit  <= 1'b0;
      cmdComplete <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      cmdComplete <= 1'b0;
      timeoutErr  <= 1'b0;
      if (xferDone && state != ST_BUSY) datInhibit <= 1'b0;
      case (state)
        ST_IDLE: if (cmdWrEn) begin
          state <= ST_SEND;
          cnt   <= CNT_W'(FRAME_BITS - 1);
          if (wrDataPres || wrRspType == RSP_BUSY) datInhibit <= 1'b1;
        end
        ST_SEND: if (cnt == '0) begin
          if (rspType == RSP_NONE) begin
            state       <= ST_IDLE;
            cmdComplete <= 1'b1;
          end else begin
            state <= ST_WAIT;
            cnt   <= '0;
          end
        end else cnt <= cnt - 1'b1;
        ST_WAIT: if (!cmdIn) begin
          state <= ST_RECV;
          cnt   <= rxLast;
        end else if (cnt == CNT_W'(TMO_CYCLES - 1)) begin
          state      <= ST_IDLE;
          timeoutErr <= 1'b1;
          if (rspType == RSP_BUSY) datInhibit <= 1'b0;
        end else cnt <= cnt + 1'b1;
        ST_RECV: if (cnt == '0) begin
          if (rspType == RSP_BUSY) state <= ST_BUSY;
          else begin
            state       <= ST_IDLE;
            cmdComplete <= 1'b1;
          end
        end else cnt <= cnt - 1'b1;
        ST_BUSY: if (dat0In) begin
          state       <= ST_IDLE;
          cmdComplete <= 1'b1;
          datInhibit  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_cmd_dp.sv
module sd_cmd_dp
  import sd_cmd_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             argWrEn,
  input  logic [ARG_W-1:0] argWrData,
  input  logic [15:0]      cmdWrData,
  input  strobe_t          strb,
  input  logic             cmdIn,
  output rspType_e         rspType,
  output logic             cmdOut,
  output logic [31:0]      rsp0,
  output logic [31:0]      rsp1,
  output logic [31:0]      rsp2,
  output logic [31:0]      rsp3,
  output logic             crcErr,
  output logic             idxErr
);
  logic [ARG_W-1:0]      argReg;
  logic [IDX_W-1:0]      idxReg;
  logic                  crcChk, idxChk;
  logic [FRAME_BITS-1:0] txShreg;
  logic [RX_KEEP-1:0]    rxShreg;
  logic [HEAD_BITS-1:0]  txHead;
  logic [FRAME_BITS-1:0] txFrame;
  logic [HEAD_BITS-1:0]  rxHead;
  logic                  unusedBits;

  assign unusedBits = ^{cmdWrData[15:14], cmdWrData[7:6], cmdWrData[2]};
  assign txHead  = {2'b01, cmdWrData[13:8], argReg};
  assign txFrame = {txHead, crc7(txHead), 1'b1};
  assign rxHead  = {1'b0, rxShreg[45:7]};
  assign cmdOut  = strb.txShift ? txShreg[FRAME_BITS-1] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      argReg  <= '0;
      idxReg  <= '0;
      crcChk  <= 1'b0;
      idxChk  <= 1'b0;
      rspType <= RSP_NONE;
      txShreg <= '1;
      rxShreg <= '0;
      rsp0 <= '0; rsp1 <= '0; rsp2 <= '0; rsp3 <= '0;
      crcErr <= 1'b0;
      idxErr <= 1'b0;
    end else begin
      crcErr <= 1'b0;
      idxErr <= 1'b0;
      if (argWrEn) argReg <= argWrData;
      if (strb.launch) begin
        idxReg  <= cmdWrData[13:8];
        idxChk  <= cmdWrData[4];
        crcChk  <= cmdWrData[3];
        rspType <= rspType_e'(cmdWrData[1:0]);
        txShreg <= txFrame;
      end else if (strb.txShift) begin
        txShreg <= {txShreg[FRAME_BITS-2:0], 1'b1};
      end
      if (strb.rxShift) rxShreg <= {rxShreg[RX_KEEP-2:0], cmdIn};
      if (strb.store) begin
        if (rspType == RSP_LONG) begin
          {rsp3, rsp2, rsp1, rsp0} <= {8'h00, rxShreg[126:7]};
        end else begin
          rsp0   <= rxShreg[38:7];
          crcErr <= crcChk && (crc7(rxHead) != rxShreg[6:0]);
          idxErr <= idxChk && (rxShreg[44:39] != idxReg);
        end
      end
    end
  end
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine
  import sd_cmd_pkg::*;
#(
  parameter int TMO_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        argWrEn,
  input  logic [31:0] argWrData,
  input  logic        cmdWrEn,
  input  logic [15:0] cmdWrData,
  input  logic        xferDone,
  input  logic        cmdIn,
  input  logic        dat0In,
  output logic        cmdOut,
  output logic        cmdOe,
  output logic        cmdInhibit,
  output logic        datInhibit,
  output logic        dat0Level,
  output logic [31:0] rsp0,
  output logic [31:0] rsp1,
  output logic [31:0] rsp2,
  output logic [31:0] rsp3,
  output logic        cmdComplete,
  output logic        timeoutErr,
  output logic        crcErr,
  output logic        indexErr,
  output logic        errSummary
);
  strobe_t  strb;
  rspType_e rspType;

  sd_cmd_ctrl #(.TMO_CYCLES(TMO_CYCLES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn),
    .wrRspType(rspType_e'(cmdWrData[1:0])), .wrDataPres(cmdWrData[5]),
    .rspType(rspType), .cmdIn(cmdIn), .dat0In(dat0In), .xferDone(xferDone),
    .strb(strb), .cmdInhibit(cmdInhibit), .datInhibit(datInhibit),
    .cmdComplete(cmdComplete), .timeoutErr(timeoutErr)
  );

  sd_cmd_dp dp_i (
    .clk(clk), .rstN(rstN), .argWrEn(argWrEn), .argWrData(argWrData),
    .cmdWrData(cmdWrData), .strb(strb), .cmdIn(cmdIn), .rspType(rspType),
    .cmdOut(cmdOut), .rsp0(rsp0), .rsp1(rsp1), .rsp2(rsp2), .rsp3(rsp3),
    .crcErr(crcErr), .idxErr(indexErr)
  );

  assign cmdOe      = strb.txShift;
  assign dat0Level  = dat0In;
  assign errSummary = timeoutErr | crcErr | indexErr;
endmodule

// File: rtl/sd_cmd_engine_chk.sv
module sd_cmd_engine_chk (
  input logic clk,
  input logic rstN,
  input logic cmdWrEn,
  input logic cmdOe,
  input logic cmdInhibit,
  input logic datInhibit,
  input logic cmdComplete,
  input logic timeoutErr,
  input logic crcErr,
  input logic indexErr,
  input logic errSummary
);
  logic [7:0] oeRun;

  always_ff @(posedge clk) begin
    if (!rstN) oeRun <= '0;
    else if (cmdOe) oeRun <= oeRun + 1'b1;
    else oeRun <= '0;
  end

  p_frame_len_r1: assert property (@(posedge clk) disable iff (!rstN)
    cmdOe |-> (oeRun < 8'd48));
  p_launch_src_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmdOe) |-> $past(cmdWrEn));
  p_tx_inhibit_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdOe |-> cmdInhibit);
  p_inhibit_end_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cmdInhibit) |-> (cmdComplete || timeoutErr));
  p_dat_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(datInhibit) |-> $past(cmdWrEn));
  p_tmo_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (!cmdComplete && errSummary && !cmdInhibit));
  p_crc_sum_r8: assert property (@(posedge clk) disable iff (!rstN)
    crcErr |-> errSummary);
  p_idx_sum_r9: assert property (@(posedge clk) disable iff (!rstN)
    indexErr |-> errSummary);
endmodule

bind sd_cmd_engine sd_cmd_engine_chk chk_i (
  .clk(clk), .rstN(rstN), .cmdWrEn(cmdWrEn), .cmdOe(cmdOe),
  .cmdInhibit(cmdInhibit), .datInhibit(datInhibit), .cmdComplete(cmdComplete),
  .timeoutErr(timeoutErr), .crcErr(crcErr), .indexErr(indexErr),
  .errSummary(errSummary)
);

// File: tb/sd_cmd_engine_tb_top.sv
module sd_cmd_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic argWrEn = 1'b0, cmdWrEn = 1'b0, xferDone = 1'b0;
  logic [31:0] argWrData = '0;
  logic [15:0] cmdWrData = '0;
  logic cmdIn = 1'b1, dat0In = 1'b1;
  logic cmdOut, cmdOe, cmdInhibit, datInhibit, dat0Level;
  logic [31:0] rsp0, rsp1, rsp2, rsp3;
  logic cmdComplete, timeoutErr, crcErr, indexErr, errSummary;

  int checks = 0, errors = 0, cycles = 0, txN = 0;
  logic [47:0] txCap = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_cmd_engine dut_i (.*);

  always @(negedge clk) begin
    cycles++;
    if (cmdOe) begin
      txCap = {txCap[46:0], cmdOut};
      txN++;
    end
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [135:0] act, input logic [135:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [6:0] crcRef(input logic [39:0] d);
    logic [6:0] r = 7'd0;
    for (int i = 39; i >= 0; i--) begin
      logic top = r[6] ^ d[i];
      r = {r[5:0], 1'b0} ^ (top ? 7'b0001001 : 7'b0);
    end
    return r;
  endfunction

  function automatic logic [47:0] frameOf(input logic [5:0] idx, input logic [31:0] arg);
    return {2'b01, idx, arg, crcRef({2'b01, idx, arg}), 1'b1};
  endfunction

  function automatic logic [135:0] rsp48(input logic [5:0] idx, input logic [31:0] pl, input bit bad);
    logic [6:0] c = crcRef({2'b00, idx, pl}) ^ (bad ? 7'h01 : 7'h00);
    return {88'd0, 2'b00, idx, pl, c, 1'b1};
  endfunction

  function automatic logic [15:0] cmdWord(input logic [5:0] idx, input bit dp, input bit ic,
                                          input bit cc, input logic [1:0] rt);
    return {2'b00, idx, 2'b00, dp, ic, cc, 1'b0, rt};
  endfunction

  task automatic issue(input logic [5:0] idx, input logic [31:0] arg, input logic [15:0] w);
    @(negedge clk); argWrEn = 1'b1; argWrData = arg;
    @(negedge clk); argWrEn = 1'b0; txN = 0; cmdWrEn = 1'b1; cmdWrData = w;
    @(negedge clk); cmdWrEn = 1'b0;
  endtask

  task automatic waitTxEnd();
    while (cmdOe) @(negedge clk);
  endtask

  task automatic sendRsp(input logic [135:0] bits, input int len, input int dly);
    repeat (dly) @(negedge clk);
    for (int i = len - 1; i >= 0; i--) begin
      cmdIn = bits[i];
      @(negedge clk);
    end
    cmdIn = 1'b1;
  endtask

  initial begin
    logic [119:0] pl120;
    logic [135:0] lng;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R3 reset cmdInhibit", cmdInhibit, 0);
    check("R4 reset datInhibit", datInhibit, 0);
    check("R1 reset idle line", {cmdOe, cmdOut}, 2'b01);

    // R5: no-response command, CRC anchor R2
    issue(6'd0, 32'h0, cmdWord(6'd0, 0, 0, 0, 2'b00));
    check("R3 inhibit after launch", cmdInhibit, 1);
    check("R4 no dat inhibit type00", datInhibit, 0);
    waitTxEnd();
    check("R1 frame length", txN, 48);
    check("R1 frame CMD0", txCap, frameOf(6'd0, 32'h0));
    check("R2 crc byte CMD0", txCap[7:0], 8'h95);
    check("R5 complete after end bit", cmdComplete, 1);
    check("R3 inhibit released", cmdInhibit, 0);
    @(negedge clk);
    check("R5 complete is a pulse", cmdComplete, 0);

    // R6 short response with both checks, R3 write ignored in flight
    issue(6'd8, 32'h1AA, cmdWord(6'd8, 0, 1, 1, 2'b10));
    repeat (3) @(negedge clk);
    cmdWrEn = 1'b1; cmdWrData = cmdWord(6'd5, 0, 0, 0, 2'b00);
    @(negedge clk); cmdWrEn = 1'b0;
    waitTxEnd();
    check("R3 frame unchanged by ignored write", txCap, frameOf(6'd8, 32'h1AA));
    check("R2 crc byte CMD8", txCap[7:0], 8'h87);
    sendRsp(rsp48(6'd8, 32'h000001AA, 0), 48, 5);
    check("R6 complete", cmdComplete, 1);
    check("R6 rsp0", rsp0, 32'h000001AA);
    check("R8 R9 no errors", {crcErr, indexErr, errSummary}, 3'b000);
    txN = 0;
    repeat (5) @(negedge clk);
    check("R3 ignored write sent nothing", txN, 0);

    // R8 CRC error with check enabled
    issue(6'd17, 32'h1234, cmdWord(6'd17, 0, 0, 1, 2'b10));
    waitTxEnd();
    sendRsp(rsp48(6'd17, 32'hCAFE0001, 1), 48, 3);
    check("R8 crc error raised", {crcErr, errSummary, cmdComplete}, 3'b111);

    // R8 bad CRC with check disabled
    issue(6'd17, 32'h1234, cmdWord(6'd17, 0, 0, 0, 2'b10));
    waitTxEnd();
    sendRsp(rsp48(6'd17, 32'hCAFE0002, 1), 48, 0);
    check("R8 crc ignored when disabled", {crcErr, errSummary, cmdComplete}, 3'b001);
    check("R6 rsp0 second", rsp0, 32'hCAFE0002);

    // R9 index mismatch
    issue(6'd13, 32'h0, cmdWord(6'd13, 0, 1, 1, 2'b10));
    waitTxEnd();
    sendRsp(rsp48(6'd12, 32'h00000900, 0), 48, 10);
    check("R9 index error", {indexErr, crcErr, errSummary}, 3'b101);

    // R7 long response packing
    pl120 = {32'hDEADBEEF, 32'h01234567, 32'h89ABCDEF, 24'h55AA33};
    lng = {8'h3F, pl120, 7'h55, 1'b1};
    issue(6'd2, 32'h0, cmdWord(6'd2, 0, 0, 1, 2'b01));
    waitTxEnd();
    sendRsp(lng, 136, 7);
    check("R7 complete", cmdComplete, 1);
    check("R7 packing", {rsp3, rsp2, rsp1, rsp0}, {8'h00, pl120});

    // R10 timeout at exact cycle
    issue(6'd55, 32'h0, cmdWord(6'd55, 0, 0, 0, 2'b10));
    waitTxEnd();
    begin
      int early = 0;
      for (int k = 1; k < 64; k++) begin
        @(negedge clk);
        if (timeoutErr || !cmdInhibit) early++;
      end
      check("R10 no early timeout", early, 0);
    end
    @(negedge clk);
    check("R10 timeout pulse", {timeoutErr, errSummary, cmdComplete, cmdInhibit}, 4'b1100);

    // R11 busy wait with R4
    dat0In = 1'b0;
    issue(6'd7, 32'h10, cmdWord(6'd7, 0, 1, 1, 2'b11));
    check("R4 dat inhibit busy type", datInhibit, 1);
    waitTxEnd();
    sendRsp(rsp48(6'd7, 32'h00000800, 0), 48, 2);
    check("R11 held during busy", {cmdComplete, cmdInhibit, dat0Level}, 3'b010);
    begin
      int seen = 0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (cmdComplete) seen++;
      end
      check("R11 no complete while DAT0 low", seen, 0);
    end
    dat0In = 1'b1;
    @(negedge clk);
    check("R11 complete on release", {cmdComplete, datInhibit, dat0Level}, 3'b101);

    // R4 data-present reservation
    issue(6'd24, 32'h200, cmdWord(6'd24, 1, 0, 0, 2'b10));
    check("R4 dat inhibit data present", datInhibit, 1);
    waitTxEnd();
    sendRsp(rsp48(6'd24, 32'h00000900, 0), 48, 1);
    check("R4 held after complete", {cmdComplete, datInhibit}, 2'b11);
    xferDone = 1'b1;
    @(negedge clk); xferDone = 1'b0;
    check("R4 cleared by xferDone", datInhibit, 0);

    repeat (3) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule